// File: doc/BRIEF.md
# Masked Alarm Repeat Scheduler

This block is the alarm section of a battery-backed real-time clock. Software programs four alarm bytes: seconds, minutes, hours and day of month. Each byte holds a BCD value and, in its top bit, a mask flag. The clock core supplies the running BCD time and a strobe once per second. On every strobe the block compares the unmasked alarm fields with the current time and raises a single-cycle interrupt pulse when they agree.

The mask flags set the repeat rate. They are read as a cascade that starts at the day field:

| Fields masked | Fields compared | Repeat rate |
|---|---|---|
| none | day, hours, minutes, seconds | monthly |
| day | hours, minutes, seconds | daily |
| day and hours | minutes, seconds | hourly |
| day, hours and minutes | seconds | every minute |
| any other combination | none | every second |

A write is checked before it is stored. A write whose BCD value falls outside the legal range for its field is dropped, and the register keeps its old contents.

Top module: `alarm_repeat_sched`

## Requirements
- R1: After reset all four alarm registers read back 0x00 and `irq` is low.
- R2: A legal write stores the whole byte, including the mask bit and any unchecked bits, and the byte reads back on `rdata` at the same `reg_sel` index: 0 seconds, 1 minutes, 2 hours, 3 day of month.
- R3: For seconds and minutes the value is bits [6:0], decoded as (bits[6:4] x 10 + bits[3:0]). A write whose decoded value exceeds 59 leaves the register unchanged.
- R4: For hours the value is bits [5:0], decoded as (bits[5:4] x 10 + bits[3:0]), and bit 6 is not checked. A write whose decoded value exceeds 23 leaves the register unchanged.
- R5: For day of month the value is bits [5:0], decoded the same way as hours. A write whose decoded value is outside 1 to 31 leaves the register unchanged.
- R6: With no bit 7 set in any register (monthly), a hit needs seconds, minutes, hours and day to all equal the time inputs.
- R7: With bit 7 set only in the day register (daily), a hit needs seconds, minutes and hours to match; the day is ignored.
- R8: With bit 7 set in the day and hours registers only (hourly), a hit needs seconds and minutes to match.
- R9: With bit 7 set in the day, hours and minutes registers only (every minute), a hit needs seconds to match.
- R10: Any other pattern of mask bits, including all four set, gives a hit on every tick.
- R11: `irq` is high for exactly the one clock cycle after the rising edge that samples `tick` high with a hit. Without a tick `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register selected by reg_sel |
| reg_sel | input | 2 | Register index: 0 seconds, 1 minutes, 2 hours, 3 day |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Contents of the selected register (combinational) |
| tick | input | 1 | One-cycle strobe, once per second |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 6 | Current day of month, BCD |
| irq | output | 1 | Alarm pulse |

## Verification
Each repeat mode is run with ticks whose time agrees with the alarm and with ticks that differ in exactly one field. A difference in a compared field must suppress the pulse, and a difference in a masked field must not; this separates every rung of the cascade from its neighbours. Mask patterns outside the cascade, such as seconds masked alone, must behave like the every-second mode.

Writes are tried at each field's range limits and just past them, including BCD nibbles above nine. Random legal writes, random mask patterns and random time values, some of them forced to match, then exercise the block alongside a bench model.

// File: rtl/alarm_sched_pkg.sv
package alarm_sched_pkg;

  localparam int NUM_FIELDS = 4;
  localparam int SEL_W      = $clog2(NUM_FIELDS);

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;

  typedef enum logic [2:0] {
    RPT_MONTH  = 3'd0,
    RPT_DAY    = 3'd1,
    RPT_HOUR   = 3'd2,
    RPT_MINUTE = 3'd3,
    RPT_SECOND = 3'd4
  } rpt_mode_e;

  // Number of value bits for each field.
  function automatic int field_width(input int idx);
    return (idx == F_SEC || idx == F_MIN) ? 7 : 6;
  endfunction

  function automatic int field_min(input int idx);
    return (idx == F_DATE) ? 1 : 0;
  endfunction

  function automatic int field_max(input int idx);
    case (idx)
      F_HOUR:  return 23;
      F_DATE:  return 31;
      default: return 59;
    endcase
  endfunction

  // Turns up to 7 BCD bits into binary (a tens digit of at most 7).
  function automatic logic [6:0] bcd_to_bin(input logic [6:0] v);
    return ({4'd0, v[6:4]} * 7'd10) + {3'd0, v[3:0]};
  endfunction

endpackage

// File: rtl/alarm_field_reg.sv
module alarm_field_reg
  import alarm_sched_pkg::*;
#(
  parameter int VAL_W = 7,
  parameter int MIN_V = 0,
  parameter int MAX_V = 59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] q
);

  localparam logic [6:0] VAL_MASK = 7'((1 << VAL_W) - 1);

  logic [7:0] q_r;
  logic [7:0] q_nxt;
  logic [6:0] dec_val;
  logic       in_range;
  logic       ld_en;

  always_comb begin
    dec_val  = bcd_to_bin(wdata[6:0] & VAL_MASK);
    in_range = (int'(dec_val) >= MIN_V) && (int'(dec_val) <= MAX_V);
    ld_en    = wr_en && in_range;
    q_nxt    = ld_en ? wdata : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 8'h00;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  // R3 with R4 and R5: a rejected write leaves the stored byte as it was
  a_r3_bad_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> $stable(q_r));

endmodule

// File: rtl/alarm_mode_decode.sv
module alarm_mode_decode
  import alarm_sched_pkg::*;
(
  input  logic [NUM_FIELDS-1:0] mask,
  output rpt_mode_e             mode,
  output logic [NUM_FIELDS-1:0] cmp_en
);

  always_comb begin
    unique case (mask)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (mode)
      RPT_MONTH:  cmp_en = 4'b1111;
      RPT_DAY:    cmp_en = 4'b0111;
      RPT_HOUR:   cmp_en = 4'b0011;
      RPT_MINUTE: cmp_en = 4'b0001;
      default:    cmp_en = 4'b0000;
    endcase
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_sched_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic [NUM_FIELDS-1:0] cmp_en,
  input  logic [NUM_FIELDS-1:0] fld_eq,
  output logic                  irq
);

  logic hit;
  logic irq_r;
  logic irq_nxt;

  always_comb begin
    hit     = &(~cmp_en | fld_eq);
    irq_nxt = tick && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_nxt;
  end

  assign irq = irq_r;

  // R11: every pulse follows a sampled tick
  a_r11_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r |-> $past(tick));

  // R10: with nothing to compare, every tick produces a pulse
  a_r10_free_run_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cmp_en == '0) |=> irq_r);

endmodule

// File: rtl/alarm_repeat_sched.sv
module alarm_repeat_sched
  import alarm_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             tick,
  input  logic [6:0]       now_sec,
  input  logic [6:0]       now_min,
  input  logic [5:0]       now_hour,
  input  logic [5:0]       now_date,
  output logic             irq
);

  logic [7:0]            fld_q   [NUM_FIELDS];
  logic [6:0]            now_val [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fld_mask;
  logic [NUM_FIELDS-1:0] fld_eq;
  logic [NUM_FIELDS-1:0] cmp_en;
  rpt_mode_e             mode;

  always_comb begin
    now_val[F_SEC]  = now_sec;
    now_val[F_MIN]  = now_min;
    now_val[F_HOUR] = {1'b0, now_hour};
    now_val[F_DATE] = {1'b0, now_date};
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int         FW    = field_width(i);
    localparam logic [6:0] VMASK = 7'((1 << FW) - 1);

    alarm_field_reg #(
      .VAL_W (FW),
      .MIN_V (field_min(i)),
      .MAX_V (field_max(i))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en && (reg_sel == SEL_W'(i))),
      .wdata (wdata),
      .q     (fld_q[i])
    );

    assign fld_mask[i] = fld_q[i][7];
    assign fld_eq[i]   = ((fld_q[i][6:0] & VMASK) == (now_val[i] & VMASK));
  end

  alarm_mode_decode u_mode (
    .mask   (fld_mask),
    .mode   (mode),
    .cmp_en (cmp_en)
  );

  alarm_match u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cmp_en (cmp_en),
    .fld_eq (fld_eq),
    .irq    (irq)
  );

  assign rdata = fld_q[reg_sel];

  // R6: in monthly mode a day mismatch blocks the pulse
  a_r6_month_needs_date: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && fld_mask == '0 && now_date != fld_q[F_DATE][5:0]) |=> !irq);

endmodule

// File: tb/alarm_repeat_sched_bench.sv
module alarm_repeat_sched_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] reg_sel;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tick;
  logic [6:0] now_sec;
  logic [6:0] now_min;
  logic [5:0] now_hour;
  logic [5:0] now_date;
  logic       irq;

  int n_vec;
  int n_bad;
  int cycles;
  logic [7:0] mdl [4];

  alarm_repeat_sched u_alarm_repeat_sched (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .tick(tick), .now_sec(now_sec), .now_min(now_min),
    .now_hour(now_hour), .now_date(now_date), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic bit legal(input int idx, input logic [7:0] v);
    int d;
    if (idx < 2) d = int'(v[6:4]) * 10 + int'(v[3:0]);
    else         d = int'(v[5:4]) * 10 + int'(v[3:0]);
    case (idx)
      0, 1:    return d <= 59;
      2:       return d <= 23;
      default: return d >= 1 && d <= 31;
    endcase
  endfunction

  function automatic bit want_irq(input logic [6:0] s, input logic [6:0] m,
                                  input logic [5:0] h, input logic [5:0] d);
    bit es, em, eh, ed;
    es = (mdl[0][6:0] == s);
    em = (mdl[1][6:0] == m);
    eh = (mdl[2][5:0] == h);
    ed = (mdl[3][5:0] == d);
    case ({mdl[3][7], mdl[2][7], mdl[1][7], mdl[0][7]})
      4'b0000: return es && em && eh && ed;
      4'b1000: return es && em && eh;
      4'b1100: return es && em;
      4'b1110: return es;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] v);
    @(negedge clk);
    reg_sel = 2'(idx);
    wdata   = v;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (legal(idx, v)) mdl[idx] = v;
  endtask

  task automatic rd_chk(input int idx, input string req);
    @(negedge clk);
    reg_sel = 2'(idx);
    #1;
    chk(rdata == mdl[idx], req, rdata, mdl[idx]);
  endtask

  task automatic tick_chk(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d,
                          input string req);
    bit e;
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_date = d;
    tick = 1'b1;
    e = want_irq(s, m, h, d);
    @(negedge clk);
    tick = 1'b0;
    chk(irq == e, req, irq, e);
    @(negedge clk);
    chk(irq == 1'b0, "R11 pulse width", irq, 0);
  endtask

  initial begin
    n_vec = 0; n_bad = 0; cycles = 0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    wr_en = 0; reg_sel = 0; wdata = 0; tick = 0;
    now_sec = 0; now_min = 0; now_hour = 0; now_date = 7'h1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 4; i++) rd_chk(i, "R1 reset value");
    chk(irq == 1'b0, "R1 irq idle", irq, 0);

    // R2 / R3 limits on seconds and minutes
    wr(0, 8'h59); rd_chk(0, "R2 sec store");
    wr(0, 8'h60); rd_chk(0, "R3 sec 60 rejected");
    wr(1, 8'h5A); rd_chk(1, "R3 min nibble A rejected");
    wr(1, 8'hC7); rd_chk(1, "R2 min with mask stored");
    wr(1, 8'h7F); rd_chk(1, "R3 min 0x7F rejected");
    // R4 hours
    wr(2, 8'h23); rd_chk(2, "R4 hour 23 stored");
    wr(2, 8'h24); rd_chk(2, "R4 hour 24 rejected");
    wr(2, 8'h45); rd_chk(2, "R4 hour bit6 unchecked");
    // R5 date
    wr(3, 8'h00); rd_chk(3, "R5 date 0 rejected");
    wr(3, 8'h31); rd_chk(3, "R5 date 31 stored");
    wr(3, 8'h32); rd_chk(3, "R5 date 32 rejected");

    // R6 monthly: 12:34:56 on day 15
    wr(0, 8'h56); wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'h15);
    tick_chk(7'h56, 7'h34, 6'h12, 6'h15, "R6 monthly hit");
    tick_chk(7'h56, 7'h34, 6'h12, 6'h16, "R6 monthly day differs");
    tick_chk(7'h56, 7'h34, 6'h13, 6'h15, "R6 monthly hour differs");
    // no tick: no irq (R11)
    @(negedge clk); now_date = 6'h15; @(negedge clk);
    chk(irq == 1'b0, "R11 no tick no irq", irq, 0);
    // R7 daily
    wr(3, 8'h95);
    tick_chk(7'h56, 7'h34, 6'h12, 6'h02, "R7 daily day ignored");
    tick_chk(7'h56, 7'h35, 6'h12, 6'h15, "R7 daily min differs");
    // R8 hourly
    wr(2, 8'h92);
    tick_chk(7'h56, 7'h34, 6'h07, 6'h09, "R8 hourly hit");
    tick_chk(7'h55, 7'h34, 6'h12, 6'h15, "R8 hourly sec differs");
    // R9 every minute
    wr(1, 8'hB4);
    tick_chk(7'h56, 7'h11, 6'h07, 6'h09, "R9 minute hit");
    tick_chk(7'h57, 7'h34, 6'h12, 6'h15, "R9 minute sec differs");
    // R10 all masked and an off-cascade pattern
    wr(0, 8'hD6);
    tick_chk(7'h01, 7'h02, 6'h03, 6'h04, "R10 all masked");
    wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'h15);
    tick_chk(7'h00, 7'h00, 6'h00, 6'h01, "R10 sec-only mask fires");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int idx;
      logic [7:0] v;
      logic [6:0] s, m;
      logic [5:0] h, d;
      if ($urandom_range(0, 2) == 0) begin
        idx = $urandom_range(0, 3);
        case (idx)
          0, 1:    v = to_bcd($urandom_range(0, 59));
          2:       v = to_bcd($urandom_range(0, 23)) | {1'b0, 1'($urandom_range(0, 1)), 6'd0};
          default: v = to_bcd($urandom_range(1, 31));
        endcase
        if ($urandom_range(0, 3) == 0) v = 8'($urandom);
        v[7] = 1'($urandom_range(0, 1));
        wr(idx, v);
        rd_chk(idx, "R2 random write readback");
      end
      if ($urandom_range(0, 1) == 0) begin
        s = mdl[0][6:0]; m = mdl[1][6:0]; h = mdl[2][5:0]; d = mdl[3][5:0];
        case ($urandom_range(0, 4))
          0: s = to_bcd($urandom_range(0, 59))[6:0];
          1: m = to_bcd($urandom_range(0, 59))[6:0];
          2: h = to_bcd($urandom_range(0, 23))[5:0];
          3: d = to_bcd($urandom_range(1, 31))[5:0];
          default: ;
        endcase
      end else begin
        s = to_bcd($urandom_range(0, 59))[6:0];
        m = to_bcd($urandom_range(0, 59))[6:0];
        h = to_bcd($urandom_range(0, 23))[5:0];
        d = to_bcd($urandom_range(1, 31))[5:0];
      end
      tick_chk(s, m, h, d, "R6 R7 R8 R9 R10 random match");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule